// File: doc/BRIEF.md
# DDR3 DLL Re-enable Command Sequencer

This block sits on the controller side of a DDR3 interface. It takes a memory device that has been running with its DLL switched off and returns it to DLL-on operation. A start request is accepted only while the device is idle with every bank precharged. The block then places the device in self refresh, tells the clock source that it may retune, and waits until the new clock has been steady for long enough. After that it brings the device out of self refresh and writes a fixed chain of mode registers: the DLL enable in MR1, the DLL reset in MR0, CWL in MR2, and the final CL and write recovery in MR0.

Each wait is a programmable minimum, given as a cycle count on an input port. The cycle in which a command appears on the bus counts as cycle 0 of the wait that follows it. All other cycles carry NOP. ODT is frozen at a static level for the whole sequence. The done flag rises only when the mode-register settle time and the DLL lock time have both run out. All outputs are registered.

Top module: `dllseq_top`

## Requirements
- R1: If start_i is high while the block is waiting for a request (after reset or after done) and dev_idle_i is low, the block asserts reject_o for exactly one cycle, in the cycle after the request. It issues no command and CKE stays high.
- R2: An accepted start (start_i and dev_idle_i both high while waiting) puts self-refresh entry on the bus in the next cycle. cke_o falls in that same cycle. CKE changes only together with self-refresh entry (falling) or exit (rising). While a sequence is running, start_i has no effect.
- R3: clk_chg_ok_o rises exactly t_cksre_i cycles after the self-refresh entry cycle and falls in the self-refresh exit cycle.
- R4: Self-refresh exit is issued in cycle max(s + t_cksrx_i + 1, e + t_ckesr_i). Here s is the first cycle of the final unbroken run of clk_stable_i high after clk_chg_ok_o rose, and e is the entry cycle. A low cycle on clk_stable_i restarts the stability count. cke_o is low from entry up to the cycle before exit.
- R5: t_xs_i cycles after exit, an MRS appears with ba_o = 1 and addr_o = mr1_val_i with bit 0 cleared (DLL on).
- R6: t_mrd_i cycles later, an MRS appears with ba_o = 0 and addr_o = mr0_val_i with bit 8 set (DLL reset).
- R7: t_mrd_i cycles after the DLL reset, an MRS appears with ba_o = 2 and addr_o = mr2_val_i. t_mrd_i cycles after that, the last MRS appears with ba_o = 0 and addr_o = mr0_val_i with bit 8 cleared.
- R8: done_o rises in cycle max(m + t_mod_i, r + t_dllk_i), where m is the last MRS cycle and r is the DLL-reset MRS cycle. It then stays high until the next accepted start.
- R9: Command codes are NOP = 0, self-refresh entry = 1, self-refresh exit = 2, MRS = 3. A sequence contains exactly entry, exit and four MRS, in that order, with NOP in every other cycle. ba_o and addr_o are zero in every cycle that is not an MRS. A count of 0 acts as 1.
- R10: From the entry cycle up to the cycle before done_o rises, odt_o holds one level. That level is 0 when rtt_on_i is high at the start; otherwise it is the value odt_req_i had at the start. When no sequence is running, odt_o follows odt_req_i one cycle later.
- R11: After reset the outputs are: cmd NOP, ba_o and addr_o zero, cke_o high, odt_o low, clk_chg_ok_o, done_o and reject_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to run the DLL re-enable sequence |
| dev_idle_i | input | 1 | Device idle with all banks precharged |
| clk_stable_i | input | 1 | New clock is present and steady |
| rtt_on_i | input | 1 | Nominal or write termination enabled |
| odt_req_i | input | 1 | ODT level wanted outside the sequence |
| t_cksre_i | input | CW | Cycles from entry until the clock may change |
| t_ckesr_i | input | CW | Minimum cycles with CKE low in self refresh |
| t_cksrx_i | input | CW | Stable-clock cycles required before exit |
| t_xs_i | input | CW | Cycles from exit to the first MRS |
| t_mrd_i | input | CW | Cycles between successive MRS commands |
| t_mod_i | input | CW | Cycles from the last MRS to done |
| t_dllk_i | input | CW | Cycles from the DLL reset MRS to done |
| mr0_val_i | input | AW | MR0 value (CL, write recovery) for the new clock |
| mr1_val_i | input | AW | MR1 value; bit 0 is forced low |
| mr2_val_i | input | AW | MR2 value (CWL) for the new clock |
| cmd_o | output | 2 | Command code |
| ba_o | output | BAW | Mode register select for MRS |
| addr_o | output | AW | Mode register data for MRS |
| cke_o | output | 1 | Clock enable to the device |
| odt_o | output | 1 | On-die termination control |
| clk_chg_ok_o | output | 1 | Clock source may retune now |
| done_o | output | 1 | Sequence complete, device ready |
| reject_o | output | 1 | Start refused, device not idle |

## Verification
The bench builds the block with its defaults: CW = 8, AW = 14, BAW = 3. With 8-bit counts it can drive a DLL lock time of 40 cycles, which is longer than the whole MRS chain, and also a lock time of 1, where the settle time decides the end. It sweeps 192 sequences over every pairing of short and long values for the seven timing counts, so each max() in R4 and R8 is tested with each side winning. For thresholds above one, it breaks clk_stable_i once to show that a break restarts the stability count. It also changes odt_req_i and pulses start_i in the middle of each sequence, to show that neither affects the outputs.

// File: rtl/dllseq_pkg.sv
package dllseq_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_SRE = 2'd1,
    CMD_SRX = 2'd2,
    CMD_MRS = 2'd3
  } ddr_cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SRWAIT,
    ST_CLKCHG,
    ST_XSWAIT,
    ST_MRD1,
    ST_MRD2,
    ST_MRD3,
    ST_MODWAIT,
    ST_DONE
  } seq_st_e;

endpackage

// File: rtl/dllseq_dly.sv
// Loadable down-counter: load value N in the issue cycle, expired from
// cycle issue+N-1 so that the next command lands N cycles after.
module dllseq_dly #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          expired_o
);
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= val_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  assign expired_o = (cnt_q <= ONE);
endmodule

// File: rtl/dllseq_stab.sv
// Counts consecutive cycles of a level; any low cycle restarts it.
module dllseq_stab #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          level_i,
  input  logic [CW-1:0] thresh_i,
  output logic          met_o
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      run_q <= '0;
    end else if (en_i) begin
      if (!level_i) begin
        run_q <= '0;
      end else if (run_q != CMAX) begin
        run_q <= run_q + CW'(1);
      end
    end
  end

  assign met_o = (run_q != '0) && (run_q >= thresh_i);
endmodule

// File: rtl/dllseq_top.sv
module dllseq_top
  import dllseq_pkg::*;
#(
  parameter int CW  = 8,
  parameter int AW  = 14,
  parameter int BAW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic           dev_idle_i,
  input  logic           clk_stable_i,
  input  logic           rtt_on_i,
  input  logic           odt_req_i,
  input  logic [CW-1:0]  t_cksre_i,
  input  logic [CW-1:0]  t_ckesr_i,
  input  logic [CW-1:0]  t_cksrx_i,
  input  logic [CW-1:0]  t_xs_i,
  input  logic [CW-1:0]  t_mrd_i,
  input  logic [CW-1:0]  t_mod_i,
  input  logic [CW-1:0]  t_dllk_i,
  input  logic [AW-1:0]  mr0_val_i,
  input  logic [AW-1:0]  mr1_val_i,
  input  logic [AW-1:0]  mr2_val_i,
  output logic [1:0]     cmd_o,
  output logic [BAW-1:0] ba_o,
  output logic [AW-1:0]  addr_o,
  output logic           cke_o,
  output logic           odt_o,
  output logic           clk_chg_ok_o,
  output logic           done_o,
  output logic           reject_o
);
  localparam int DLLOFF_BIT = 0;
  localparam int DLLRST_BIT = 8;
  localparam logic [AW-1:0] DLLOFF_M = AW'(1) << DLLOFF_BIT;
  localparam logic [AW-1:0] DLLRST_M = AW'(1) << DLLRST_BIT;
  localparam logic [BAW-1:0] SEL_MR0 = BAW'(0);
  localparam logic [BAW-1:0] SEL_MR1 = BAW'(1);
  localparam logic [BAW-1:0] SEL_MR2 = BAW'(2);

  seq_st_e        st_q, st_n;
  ddr_cmd_e       cmd_n;
  logic [1:0]     cmd_q;
  logic [BAW-1:0] ba_q, ba_n;
  logic [AW-1:0]  addr_q, addr_n;
  logic           cke_q, cke_n;
  logic           odt_q, odt_n;
  logic           chg_q, chg_n;
  logic           done_q, done_n;
  logic           rej_q, rej_n;
  logic           hold_q, hold_n;
  logic           seq_busy, busy_n;

  logic           main_ld, esr_ld, dllk_ld, stab_clr;
  logic [CW-1:0]  main_val;
  logic           main_exp, esr_exp, dllk_exp, stab_met;

  dllseq_dly #(.CW(CW)) u_main (
    .clk(clk), .rst(rst), .load_i(main_ld), .val_i(main_val),
    .expired_o(main_exp)
  );

  dllseq_dly #(.CW(CW)) u_ckesr (
    .clk(clk), .rst(rst), .load_i(esr_ld), .val_i(t_ckesr_i),
    .expired_o(esr_exp)
  );

  dllseq_dly #(.CW(CW)) u_dllk (
    .clk(clk), .rst(rst), .load_i(dllk_ld), .val_i(t_dllk_i),
    .expired_o(dllk_exp)
  );

  dllseq_stab #(.CW(CW)) u_stab (
    .clk(clk), .rst(rst), .clr_i(stab_clr), .en_i(st_q == ST_CLKCHG),
    .level_i(clk_stable_i), .thresh_i(t_cksrx_i), .met_o(stab_met)
  );

  always_comb begin
    st_n     = st_q;
    cmd_n    = CMD_NOP;
    ba_n     = '0;
    addr_n   = '0;
    cke_n    = cke_q;
    chg_n    = chg_q;
    done_n   = done_q;
    rej_n    = 1'b0;
    hold_n   = hold_q;
    main_ld  = 1'b0;
    main_val = '0;
    esr_ld   = 1'b0;
    dllk_ld  = 1'b0;
    stab_clr = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          if (dev_idle_i) begin
            st_n     = ST_SRWAIT;
            cmd_n    = CMD_SRE;
            cke_n    = 1'b0;
            done_n   = 1'b0;
            main_ld  = 1'b1;
            main_val = t_cksre_i;
            esr_ld   = 1'b1;
            hold_n   = rtt_on_i ? 1'b0 : odt_req_i;
          end else begin
            rej_n = 1'b1;
          end
        end
      end
      ST_SRWAIT: begin
        if (main_exp) begin
          st_n     = ST_CLKCHG;
          chg_n    = 1'b1;
          stab_clr = 1'b1;
        end
      end
      ST_CLKCHG: begin
        if (stab_met && esr_exp) begin
          st_n     = ST_XSWAIT;
          cmd_n    = CMD_SRX;
          cke_n    = 1'b1;
          chg_n    = 1'b0;
          main_ld  = 1'b1;
          main_val = t_xs_i;
        end
      end
      ST_XSWAIT: begin
        if (main_exp) begin
          st_n     = ST_MRD1;
          cmd_n    = CMD_MRS;
          ba_n     = SEL_MR1;
          addr_n   = mr1_val_i & ~DLLOFF_M;
          main_ld  = 1'b1;
          main_val = t_mrd_i;
        end
      end
      ST_MRD1: begin
        if (main_exp) begin
          st_n     = ST_MRD2;
          cmd_n    = CMD_MRS;
          ba_n     = SEL_MR0;
          addr_n   = mr0_val_i | DLLRST_M;
          main_ld  = 1'b1;
          main_val = t_mrd_i;
          dllk_ld  = 1'b1;
        end
      end
      ST_MRD2: begin
        if (main_exp) begin
          st_n     = ST_MRD3;
          cmd_n    = CMD_MRS;
          ba_n     = SEL_MR2;
          addr_n   = mr2_val_i;
          main_ld  = 1'b1;
          main_val = t_mrd_i;
        end
      end
      ST_MRD3: begin
        if (main_exp) begin
          st_n     = ST_MODWAIT;
          cmd_n    = CMD_MRS;
          ba_n     = SEL_MR0;
          addr_n   = mr0_val_i & ~DLLRST_M;
          main_ld  = 1'b1;
          main_val = t_mod_i;
        end
      end
      ST_MODWAIT: begin
        if (main_exp && dllk_exp) begin
          st_n   = ST_DONE;
          done_n = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  assign busy_n   = (st_n != ST_IDLE) && (st_n != ST_DONE);
  assign seq_busy = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign odt_n    = busy_n ? hold_n : odt_req_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      cke_q  <= 1'b1;
      odt_q  <= 1'b0;
      chg_q  <= 1'b0;
      done_q <= 1'b0;
      rej_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cmd_q  <= cmd_n;
      ba_q   <= ba_n;
      addr_q <= addr_n;
      cke_q  <= cke_n;
      odt_q  <= odt_n;
      chg_q  <= chg_n;
      done_q <= done_n;
      rej_q  <= rej_n;
      hold_q <= hold_n;
    end
  end

  assign cmd_o        = cmd_q;
  assign ba_o         = ba_q;
  assign addr_o       = addr_q;
  assign cke_o        = cke_q;
  assign odt_o        = odt_q;
  assign clk_chg_ok_o = chg_q;
  assign done_o       = done_q;
  assign reject_o     = rej_q;
endmodule

// File: rtl/dllseq_chk.sv
module dllseq_chk
  import dllseq_pkg::*;
#(
  parameter int CW  = 8,
  parameter int AW  = 14,
  parameter int BAW = 3
) (
  input logic           clk,
  input logic           rst,
  input logic [CW-1:0]  t_mrd_i,
  input logic [CW-1:0]  t_dllk_i,
  input logic [1:0]     cmd_o,
  input logic [BAW-1:0] ba_o,
  input logic [AW-1:0]  addr_o,
  input logic           cke_o,
  input logic           odt_o,
  input logic           done_o,
  input logic           reject_o,
  input logic           seq_busy
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  logic [CW-1:0] gap_q;
  logic [CW-1:0] lock_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      lock_q <= '0;
    end else begin
      if (cmd_o != CMD_NOP) gap_q <= CW'(1);
      else if (gap_q != CMAX) gap_q <= gap_q + CW'(1);
      if (cmd_o == CMD_MRS && ba_o == BAW'(0) && addr_o[8]) lock_q <= CW'(1);
      else if (lock_q != CMAX) lock_q <= lock_q + CW'(1);
    end
  end

  // R2
  cke_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(cke_o) |-> cmd_o == CMD_SRE);

  // R4
  cke_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cke_o) |-> cmd_o == CMD_SRX);

  // R1
  reject_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    reject_o |-> (cmd_o == CMD_NOP && cke_o));

  // R5
  mr1_dll_on_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_MRS && ba_o == BAW'(1)) |-> !addr_o[0]);

  // R7
  mrd_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == CMD_MRS && ba_o == BAW'(2)) |-> gap_q >= t_mrd_i);

  // R8
  dllk_wait_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> lock_q >= t_dllk_i);

  // R10
  odt_static_chk: assert property (@(posedge clk) disable iff (rst)
    (seq_busy && $past(seq_busy)) |-> $stable(odt_o));

  // R9
  nonmrs_fields_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_o != CMD_MRS) |-> (ba_o == '0 && addr_o == '0));
endmodule

bind dllseq_top dllseq_chk #(.CW(CW), .AW(AW), .BAW(BAW)) u_chk (.*);

// File: tb/tb_dllseq_top.sv
`timescale 1ns/1ps
module tb_dllseq_top;
  localparam int CW = 8, AW = 14, BAW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, dev_idle_i = 0, clk_stable_i = 0, rtt_on_i = 0, odt_req_i = 0;
  logic [CW-1:0] t_cksre_i = 1, t_ckesr_i = 1, t_cksrx_i = 1, t_xs_i = 1;
  logic [CW-1:0] t_mrd_i = 1, t_mod_i = 1, t_dllk_i = 1;
  logic [AW-1:0] mr0_val_i = 0, mr1_val_i = 0, mr2_val_i = 0;
  logic [1:0] cmd_o;
  logic [BAW-1:0] ba_o;
  logic [AW-1:0] addr_o;
  logic cke_o, odt_o, clk_chg_ok_o, done_o, reject_o;

  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  dllseq_top #(.CW(CW), .AW(AW), .BAW(BAW)) dut (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
  endtask

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic run_one(input int idx);
    int sre = -1, srx = -1, chg = -1, sl = -1, d = -1, ncmd = 0, nmrs = 0;
    int cke_bad = 0, odt_bad = 0, fld_bad = 0, order_bad = 0, done_bad = 0;
    int mt[4];
    int mba[4];
    int mad[4];
    int ts, xs, mrd, mod, dllk, cksrx, ckesr, cksre;
    logic odt_exp;
    mrd   = 1 + idx % 3;
    xs    = ((idx / 3) % 2 != 0) ? 4 : 1;
    dllk  = ((idx / 6) % 2 != 0) ? 40 : 1;
    mod   = ((idx / 12) % 2 != 0) ? 5 : 1;
    cksrx = ((idx / 24) % 2 != 0) ? 3 : 1;
    ckesr = ((idx / 48) % 2 != 0) ? 9 : 1;
    cksre = ((idx / 96) % 2 != 0) ? 3 : 1;
    t_mrd_i = CW'(mrd); t_xs_i = CW'(xs); t_dllk_i = CW'(dllk); t_mod_i = CW'(mod);
    t_cksrx_i = CW'(cksrx); t_ckesr_i = CW'(ckesr); t_cksre_i = CW'(cksre);
    rtt_on_i  = ((idx / 7) % 2) != 0;
    odt_req_i = ((idx / 5) % 2) != 0;
    mr0_val_i = AW'(idx * 37 + 5) | AW'(14'h0100);
    mr1_val_i = AW'(idx * 53) | AW'(1);
    mr2_val_i = AW'(idx * 11 + 3);
    odt_exp = rtt_on_i ? 1'b0 : odt_req_i;
    for (int k = 0; k < 4; k++) begin mt[k] = -1; mba[k] = -1; mad[k] = -1; end
    dev_idle_i = 1;
    start_i = 1;
    ts = cyc;
    for (int n = 0; n < 3000; n++) begin
      step();
      start_i = 0;
      odt_req_i = ~odt_req_i;
      case (cmd_o)
        2'd1: begin if (ncmd != 0) order_bad++; sre = cyc; ncmd++; end
        2'd2: begin if (ncmd != 1) order_bad++; srx = cyc; ncmd++; end
        2'd3: begin
          if (ncmd < 2 || nmrs > 3) order_bad++;
          else begin mt[nmrs] = cyc; mba[nmrs] = int'(ba_o); mad[nmrs] = int'(addr_o); end
          nmrs++; ncmd++;
        end
        default: if (ba_o != 0 || addr_o != 0) fld_bad++;
      endcase
      if (cke_o !== ((sre < 0) || (srx >= 0))) cke_bad++;
      if (clk_chg_ok_o && chg < 0) chg = cyc;
      if (clk_chg_ok_o && srx >= 0) cke_bad++;
      if (chg >= 0 && srx < 0) begin
        if (cyc == chg + 1) begin clk_stable_i = 1; sl = cyc; start_i = 1; end
        if (cksrx >= 2 && cyc == chg + 2) clk_stable_i = 0;
        if (cksrx >= 2 && cyc == chg + 3) begin clk_stable_i = 1; sl = cyc; end
      end
      if (srx >= 0) clk_stable_i = 0;
      if (done_o && d < 0) d = cyc;
      if (sre >= 0 && d < 0 && odt_o !== odt_exp) odt_bad++;
      if (d < 0 && done_o) done_bad++;
      if (sre >= 0 && d < 0 && cyc > sre && done_o) done_bad++;
      if (d >= 0 && cyc > d) begin
        if (!done_o || cmd_o != 2'd0) done_bad++;
        if (cyc >= d + 2) break;
      end
    end
    chk(sre == ts + 1, "R2", "entry cycle", sre, ts + 1);
    chk(ncmd == 6 && order_bad == 0, "R9", "command count/order", ncmd, 6);
    chk(fld_bad == 0, "R9", "fields on NOP", fld_bad, 0);
    chk(chg - sre == cksre, "R3", "clock change permit delay", chg - sre, cksre);
    chk(srx == imax(sl + cksrx + 1, sre + ckesr), "R4", "exit cycle", srx,
        imax(sl + cksrx + 1, sre + ckesr));
    chk(cke_bad == 0, "R4", "cke/permit window", cke_bad, 0);
    chk(mt[0] - srx == xs && mba[0] == 1, "R5", "MR1 timing/select", mt[0] - srx, xs);
    chk(mad[0] == int'(mr1_val_i & ~AW'(1)), "R5", "MR1 data", mad[0],
        int'(mr1_val_i & ~AW'(1)));
    chk(mt[1] - mt[0] == mrd && mba[1] == 0, "R6", "DLL reset timing/select",
        mt[1] - mt[0], mrd);
    chk(mad[1] == int'(mr0_val_i | AW'(14'h0100)), "R6", "DLL reset data", mad[1],
        int'(mr0_val_i | AW'(14'h0100)));
    chk(mt[2] - mt[1] == mrd && mba[2] == 2 && mad[2] == int'(mr2_val_i), "R7",
        "MR2 write", mt[2] - mt[1], mrd);
    chk(mt[3] - mt[2] == mrd && mba[3] == 0 &&
        mad[3] == int'(mr0_val_i & ~AW'(14'h0100)), "R7", "MR0 update", mad[3],
        int'(mr0_val_i & ~AW'(14'h0100)));
    chk(d == imax(mt[3] + mod, mt[1] + dllk), "R8", "done cycle", d,
        imax(mt[3] + mod, mt[1] + dllk));
    chk(done_bad == 0, "R8", "done level", done_bad, 0);
    chk(odt_bad == 0, "R10", "odt static level", odt_bad, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int quiet_bad;
    repeat (4) step();
    rst = 0;
    step();
    // R11 reset state
    chk(cmd_o == 2'd0 && ba_o == 0 && addr_o == 0, "R11", "cmd/fields", cmd_o, 0);
    chk(cke_o == 1 && odt_o == 0, "R11", "cke/odt", {cke_o, odt_o}, 2);
    chk(!clk_chg_ok_o && !done_o && !reject_o, "R11", "flags",
        {clk_chg_ok_o, done_o, reject_o}, 0);
    // R10 idle follow
    odt_req_i = 1;
    step();
    chk(odt_o == 1, "R10", "idle odt follows", odt_o, 1);
    odt_req_i = 0;
    step();
    chk(odt_o == 0, "R10", "idle odt follows low", odt_o, 0);
    // R1 rejected start
    dev_idle_i = 0;
    start_i = 1;
    step();
    start_i = 0;
    chk(reject_o == 1 && cmd_o == 2'd0, "R1", "reject pulse", reject_o, 1);
    quiet_bad = 0;
    for (int k = 0; k < 6; k++) begin
      step();
      if (reject_o || cmd_o != 2'd0 || !cke_o) quiet_bad++;
    end
    chk(quiet_bad == 0, "R1", "quiet after reject", quiet_bad, 0);
    for (int i = 0; i < 192; i++) run_one(i);
    // R1 reject also from the done state
    dev_idle_i = 0;
    start_i = 1;
    step();
    start_i = 0;
    chk(reject_o == 1 && cmd_o == 2'd0 && done_o, "R1", "reject after done",
        reject_o, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule